// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus interface unit of a small 8-bit processor core. The core hands it one machine-cycle request at a time: a cycle kind (opcode fetch, memory read, memory write, I/O read, I/O write or a bus idle cycle), a 16-bit address and a write byte. The sequencer steps through T-states, one per clock, and drives the external pins for that cycle. The low address byte and the data byte share one set of bidirectional pins. An address latch enable pulse in the first T-state tells outside logic when to catch the low address.

The read and write strobes are active low and fall in the second and third T-states. Write data goes onto the shared pins as soon as the address phase ends. Read data is taken from the pins on the clock edge that closes the third T-state. The block reports on a 3-bit status output which kind of cycle is running. It returns the captured byte and a one-clock completion pulse in the final T-state. The core may place its next request while that pulse is high, so cycles can follow each other with no gap.

Top module: `mux_bus_seq`

## Requirements
- R1: While `rst` is high and on the first clock after it, `rd_n` and `wr_n` are 1, `ale` is 0, `ad_oe` is 0 with `ad` released, `a_hi` is 0, `status` is 000 and `done` is 0.
- R2: `ale` is 1 during T1 of every cycle that is not a bus idle cycle, and 0 at every other time.
- R3: During T1 of a non-idle cycle, `ad` carries `req_addr[7:0]`. During T1, T2 and T3 of a non-idle cycle, `a_hi` carries `req_addr[15:8]`. At every other time `a_hi` is 0.
- R4: A bus idle cycle (`req_kind` 0) lasts three T-states. Throughout it there is no `ale`, `ad` is released, `a_hi` is 0, no strobe is active and `status` is 000.
- R5: `rd_n` is 0 in T2 and T3 of fetch, memory read and I/O read cycles. `wr_n` is 0 in T2 and T3 of memory write and I/O write cycles. Both are 1 at all other times, and the two are never 0 together.
- R6: In write cycles, `ad` carries `req_wdata` with `ad_oe` = 1 from the start of T2 to the end of T3. In all other cycles `ad` is released after T1.
- R7: In read and fetch cycles, the byte on `ad` is captured at the clock edge that ends T3. It appears on `rdata` from the next T-state on and is held until the next read capture.
- R8: An opcode fetch (`req_kind` 1) lasts four T-states, and T4 has no strobe and no bus drive. Every other kind lasts three. `done` is 1 for exactly the final T-state.
- R9: `status` = {io_m, s1, s0} is 011 for fetch, 010 for memory read, 001 for memory write, 110 for I/O read and 101 for I/O write. The code is held from T1 to the final T-state, and it is 000 when no cycle is running.
- R10: A request is taken only when no cycle is running or while `done` is 1. `req_valid` and request fields applied at any other time have no effect on the running cycle.
- R11: Kind codes 2 (memory read), 3 (memory write), 4 (I/O read) and 5 (I/O write) are decoded as listed. Unused codes 6 and 7 run as bus idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind: 0 idle, 1 fetch, 2 mem read, 3 mem write, 4 I/O read, 5 I/O write |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| ale | output | 1 | Address latch enable, active high |
| a_hi | output | 8 | High address byte |
| ad | inout | 8 | Shared low-address / data pins |
| ad_oe | output | 1 | High while the block drives `ad` |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| status | output | 3 | Cycle kind code {io_m, s1, s0} |
| rdata | output | 8 | Last captured read byte |
| done | output | 1 | High in the final T-state |

## Verification
The end of one cycle and the start of the next can meet in the same clock. The T-state that raises `done` is also the one in which the next request is taken, so the following edge has to open a fresh T1 and not fall back to rest. The bench provokes this by holding `req_valid` high with a second request across the final T-state. It then requires `ale`, the new low address and the new status code in the very next T-state. It also checks that the same request, presented earlier in the running cycle, left that cycle untouched.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    localparam int HI_W  = ADDR_W - DATA_W;

    typedef enum logic [2:0] {
        K_IDLE  = 3'd0,
        K_FETCH = 3'd1,
        K_MRD   = 3'd2,
        K_MWR   = 3'd3,
        K_IORD  = 3'd4,
        K_IOWR  = 3'd5
    } cyc_e;

    typedef enum logic [2:0] {
        TS_OFF = 3'd0,
        TS_T1  = 3'd1,
        TS_T2  = 3'd2,
        TS_T3  = 3'd3,
        TS_T4  = 3'd4
    } tstate_e;

    typedef struct packed {
        logic io_m;
        logic s1;
        logic s0;
    } stat_t;

    typedef struct packed {
        cyc_e              kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic cyc_e decode_kind(input logic [2:0] code);
        case (code)
            3'd1:    return K_FETCH;
            3'd2:    return K_MRD;
            3'd3:    return K_MWR;
            3'd4:    return K_IORD;
            3'd5:    return K_IOWR;
            default: return K_IDLE;
        endcase
    endfunction

    function automatic logic is_read(input cyc_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic is_write(input cyc_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic tstate_e last_ts(input cyc_e k);
        return (k == K_FETCH) ? TS_T4 : TS_T3;
    endfunction

    function automatic stat_t stat_of(input cyc_e k);
        case (k)
            K_FETCH: return '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
            K_MRD:   return '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
            K_MWR:   return '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
            K_IORD:  return '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
            K_IOWR:  return '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
            default: return '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};
        endcase
    endfunction

endpackage

// File: rtl/mbs_seq.sv
module mbs_seq
    import mbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  req_t              req_in,
    input  logic [DATA_W-1:0] rd_sample,
    output tstate_e           ts,
    output req_t              cur,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    logic take;

    assign done = (ts != TS_OFF) && (ts == last_ts(cur.kind));
    assign take = req_valid && ((ts == TS_OFF) || done);

    always_ff @(posedge clk) begin
        if (rst) begin
            ts    <= TS_OFF;
            cur   <= '0;
            rdata <= '0;
        end else begin
            if (take) begin
                ts  <= TS_T1;
                cur <= req_in;
            end else if (done) begin
                ts <= TS_OFF;
            end else begin
                case (ts)
                    TS_T1:   ts <= TS_T2;
                    TS_T2:   ts <= TS_T3;
                    TS_T3:   ts <= TS_T4;
                    default: ts <= TS_OFF;
                endcase
            end
            if ((ts == TS_T3) && is_read(cur.kind)) begin
                rdata <= rd_sample;
            end
        end
    end

    AST_T4_ONLY_FETCH: assert property (@(posedge clk) disable iff (rst)
        (ts == TS_T4) |-> (cur.kind == K_FETCH)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !($past(ts) == TS_T3 && is_read($past(cur.kind))) |-> $stable(rdata)); // R7

    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        (ts == TS_T1) |=> (ts == TS_T2)); // R10

endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
    import mbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tstate_e           ts,
    input  req_t              cur,
    output logic              ale,
    output logic [HI_W-1:0]   a_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              rd_n,
    output logic              wr_n,
    output stat_t             status
);

    logic quiet;
    logic addr_phase;
    logic strobe_phase;

    assign quiet        = (cur.kind == K_IDLE);
    assign addr_phase   = (ts == TS_T1) || (ts == TS_T2) || (ts == TS_T3);
    assign strobe_phase = (ts == TS_T2) || (ts == TS_T3);

    always_comb begin
        ale    = (ts == TS_T1) && !quiet;
        a_hi   = (addr_phase && !quiet) ? cur.addr[ADDR_W-1:DATA_W] : '0;
        ad_oe  = !quiet && ((ts == TS_T1) || (strobe_phase && is_write(cur.kind)));
        ad_out = (ts == TS_T1) ? cur.addr[DATA_W-1:0] : cur.wdata;
        rd_n   = !(strobe_phase && is_read(cur.kind));
        wr_n   = !(strobe_phase && is_write(cur.kind));
        status = (ts != TS_OFF) ? stat_of(cur.kind) : '0;
    end

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R5

    AST_ALE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale); // R2

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe); // R6

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
        ((ts == TS_T2) || (ts == TS_T3) || (ts == TS_T4)) |-> $stable(status)); // R9

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     ale,
    output logic [HI_W-1:0]          a_hi,
    inout  wire  [DATA_W-1:0]        ad,
    output logic                     ad_oe,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [2:0]               status,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);

    req_t              req_in;
    req_t              cur;
    tstate_e           ts;
    stat_t             st;
    logic [DATA_W-1:0] ad_out;

    always_comb begin
        req_in.kind  = decode_kind(req_kind);
        req_in.addr  = req_addr;
        req_in.wdata = req_wdata;
    end

    mbs_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .rd_sample (ad),
        .ts        (ts),
        .cur       (cur),
        .done      (done),
        .rdata     (rdata)
    );

    mbs_pins u_pins (
        .clk    (clk),
        .rst    (rst),
        .ts     (ts),
        .cur    (cur),
        .ale    (ale),
        .a_hi   (a_hi),
        .ad_out (ad_out),
        .ad_oe  (ad_oe),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .status (st)
    );

    assign status = st;
    assign ad     = ad_oe ? ad_out : 'z;

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (status == 3'b000) |-> (!ale && !ad_oe && rd_n && wr_n)); // R4

    AST_DONE_ENDS_OR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        done |=> (status == 3'b000 || ale || (a_hi == '0 && !ad_oe))); // R8

endmodule

// File: tb/sim_mux_bus_seq.sv
module sim_mux_bus_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0] req_wdata = 8'h0;
    logic       ale;
    logic [7:0] a_hi;
    wire  [7:0] ad;
    logic       ad_oe;
    logic       rd_n;
    logic       wr_n;
    logic [2:0] status;
    logic [7:0] rdata;
    logic       done;
    logic [7:0] periph = 8'h0;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] exp_rdata = 8'h0;

    always #4 clk = ~clk;

    assign ad = (rd_n == 1'b0) ? periph : 8'hzz;

    mux_bus_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ale(ale), .a_hi(a_hi),
        .ad(ad), .ad_oe(ad_oe), .rd_n(rd_n), .wr_n(wr_n), .status(status),
        .rdata(rdata), .done(done)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit k_quiet(input int k); return (k == 0) || (k >= 6); endfunction
    function automatic bit k_rd(input int k); return (k == 1) || (k == 2) || (k == 4); endfunction
    function automatic bit k_wr(input int k); return (k == 3) || (k == 5); endfunction
    function automatic int k_len(input int k); return (k == 1) ? 4 : 3; endfunction
    function automatic logic [2:0] k_stat(input int k);
        case (k)
            1: return 3'b011;
            2: return 3'b010;
            3: return 3'b001;
            4: return 3'b110;
            5: return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk_state(input int k, input int t, input logic [15:0] a, input logic [7:0] wd);
        bit q = k_quiet(k);
        bit strobe = (t == 2) || (t == 3);
        bit oe = !q && (t == 1 || (k_wr(k) && strobe));
        chk("R2 ale", {15'd0, ale}, {15'd0, (t == 1) && !q});
        chk("R3 a_hi", {8'd0, a_hi}, (!q && t <= 3) ? {8'd0, a[15:8]} : 16'd0);
        chk("R6 ad_oe", {15'd0, ad_oe}, {15'd0, oe});
        if (t == 1 && !q) chk("R3 ad low addr", {8'd0, ad}, {8'd0, a[7:0]});
        else if (oe) chk("R6 ad wdata", {8'd0, ad}, {8'd0, wd});
        else if (!(k_rd(k) && strobe)) chk("R4 ad released", {8'd0, ad}, {8'd0, 8'hzz});
        chk("R5 rd_n", {15'd0, rd_n}, {15'd0, !(k_rd(k) && strobe)});
        chk("R5 wr_n", {15'd0, wr_n}, {15'd0, !(k_wr(k) && strobe)});
        chk("R9 status", {13'd0, status}, {13'd0, k_stat(k)});
        chk("R8 done", {15'd0, done}, {15'd0, t == k_len(k)});
    endtask

    task automatic one_cycle(input int k, input logic [15:0] a, input logic [7:0] wd, input logic [7:0] rv);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(k); req_addr = a; req_wdata = wd; periph = rv;
        for (int t = 1; t <= k_len(k); t++) begin
            @(negedge clk);
            chk_state(k, t, a, wd);
            if (t <= 2) begin
                // R10: noise request while busy must not disturb the cycle
                req_valid = 1'b1; req_kind = 3'(k ^ 3); req_addr = ~a; req_wdata = ~wd;
            end else begin
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        if (k_rd(k)) exp_rdata = rv;
        chk("R7 rdata", {8'd0, rdata}, {8'd0, exp_rdata});
        chk("R8 done low after", {15'd0, done}, 16'd0);
        chk("R9 status off", {13'd0, status}, 16'd0);
        chk("R11 a_hi off", {8'd0, a_hi}, 16'd0);
    endtask

    task automatic back_to_back(input int ka, input logic [15:0] aa, input int kb, input logic [15:0] ab);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(ka); req_addr = aa; req_wdata = 8'h3C; periph = 8'hC3;
        @(negedge clk);
        req_kind = 3'(kb); req_addr = ab; req_wdata = 8'h96;
        for (int t = 2; t <= k_len(ka); t++) @(negedge clk);
        chk("R8 done first", {15'd0, done}, 16'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk_state(kb, 1, ab, 8'h96);
        for (int t = 2; t <= k_len(kb); t++) begin
            @(negedge clk);
            chk_state(kb, t, ab, 8'h96);
        end
        if (k_rd(ka) || k_rd(kb)) exp_rdata = 8'hC3;
        @(negedge clk);
        chk("R10 idle after pair", {13'd0, status}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_n", {15'd0, rd_n}, 16'd1);
        chk("R1 wr_n", {15'd0, wr_n}, 16'd1);
        chk("R1 ale", {15'd0, ale}, 16'd0);
        chk("R1 ad_oe", {15'd0, ad_oe}, 16'd0);
        chk("R1 status", {13'd0, status}, 16'd0);
        chk("R1 done", {15'd0, done}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {8'd0, a_hi}, 16'd0);
        chk("R1 rdata", {8'd0, rdata}, 16'd0);
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 4; i++) begin
                logic [15:0] a;
                logic [7:0] wd;
                case (i)
                    0: a = 16'h0000;
                    1: a = 16'hFFFF;
                    2: a = 16'h12A5;
                    default: a = 16'h8001 + 16'(k * 16'h0101);
                endcase
                wd = (a[7:0] ^ 8'h5A) + 8'(k * 7 + i);
                one_cycle(k, a, wd, ~wd);
            end
        end
        back_to_back(2, 16'hA1B2, 3, 16'h4C5D);
        back_to_back(1, 16'h0F0E, 5, 16'hE0F1);
        back_to_back(0, 16'h7777, 4, 16'h2468);
        back_to_back(4, 16'h1357, 1, 16'h9ABC);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule